// File: doc/BRIEF.md
# Differential CPU Clock Stop Controller

This block produces a set of differential processor clock pairs from a fast reference clock and parks them on request. An active-low stop input, which may change at any time, is sampled on processor clock edges. Once the request has passed two such edges, every pair that is not exempt finishes its current swing and holds with its true output high and its complement output undriven. An external termination then pulls the complement low. When the request is withdrawn, the parked pairs resume toggling on a clean edge and do not emit a shortened pulse.

Each pair has two configuration bits, loaded by a write strobe. One bit exempts the pair from the stop request. The other disables the pair, which then parks in the same way whatever the stop input does. A status output gives the level of the stop input as seen after synchronization. Each output is modelled as a logic level, and the complement also has a drive-enable.

Top module: `cpu_clk_stop_ctrl`

## Requirements
- R1: After reset every pair is enabled and stoppable, toggles, and drives its complement as the inverse of its true output. Asserting reset during operation restores these defaults.
- R2: A running pair changes its true output only on a processor clock edge, and these edges fall once every HALF_DIV reference cycles. With HALF_DIV = 2 a running pair makes exactly 8 transitions in 16 reference cycles.
- R3: A falling stop input acts only from the third processor edge after the fall. A stoppable pair whose true output is high at the fall makes 2 more transitions. One whose true output is low makes 3.
- R4: A parked pair holds its true output at 1, its complement at 0 and its complement drive-enable at 0, and makes no further transitions while the park condition holds.
- R5: A pair whose free-run bit is 1 keeps toggling at its normal rate while the stop input is low.
- R6: A pair whose enable bit is 0 parks as in R4, even when its free-run bit is 1. Setting the bit back to 1 resumes toggling.
- R7: After the stop input rises, a parked pair toggles again from the third processor edge after the rise. Its first transition is a fall of the true output. With HALF_DIV = 2 it makes 6 transitions in the 16 reference cycles that follow the rise.
- R8: The status output is 0 when the stop input has been low for the last two processor edges, and 1 when it has been high for them. It changes only on processor edges.
- R9: A one-cycle pulse on the write strobe loads the enable and free-run vectors. Bit i of each vector belongs to pair i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_n | input | 1 | Asynchronous active-low stop request |
| cfg_wr | input | 1 | Strobe that loads the configuration vectors |
| cfg_en | input | NUM_PAIRS | Enable bit per pair (1 = enabled) |
| cfg_fr | input | NUM_PAIRS | Free-run bit per pair (1 = exempt from stop) |
| clk_t | output | NUM_PAIRS | True output of each pair |
| clk_c | output | NUM_PAIRS | Complement output level of each pair |
| clk_c_oe | output | NUM_PAIRS | Complement drive-enable (0 = undriven) |
| stop_seen_n | output | 1 | Synchronized level of the stop input |

## Verification
The bench applies the stop request at random offsets against the processor clock phase, for each of the eight free-run masks. It counts transitions per pair and compares the counts with 2 or 3, set by the true level at the moment of the request. A design that sampled over only one edge, or that parked at the wrong level, gives a count that is off by one. The release window checks that exactly six transitions follow and that the first of them is a fall. A design that glitched on release, or that restarted high, breaks this count or the fall check. The bench also covers a disabled pair that is also marked free-running, and a reset issued over a non-default configuration. These catch an enable that does not dominate the free-run bit and defaults that are not restored.

// File: rtl/cstop_pkg.sv
package cstop_pkg;
  typedef enum logic {
    PS_RUN  = 1'b0,
    PS_PARK = 1'b1
  } pair_st_e;
endpackage

// File: rtl/cstop_tick_gen.sv
module cstop_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cstop_req_sync.sv
module cstop_req_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop_n,
  output logic stop_seen_n
);
  logic s1_q, s1_d, s2_q, s2_d;

  always_comb begin
    s1_d = s1_q;
    s2_d = s2_q;
    if (tick) begin
      s1_d = stop_n;
      s2_d = s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign stop_seen_n = s2_q;
endmodule

// File: rtl/cstop_cfg.sv
module cstop_cfg #(
  parameter int NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [NP-1:0] en_in,
  input  logic [NP-1:0] fr_in,
  output logic [NP-1:0] en_q,
  output logic [NP-1:0] fr_q
);
  logic [NP-1:0] en_d, fr_d;

  always_comb begin
    en_d = wr ? en_in : en_q;
    fr_d = wr ? fr_in : fr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
      fr_q <= '0;
    end else begin
      en_q <= en_d;
      fr_q <= fr_d;
    end
  end
endmodule

// File: rtl/cstop_pair.sv
module cstop_pair
  import cstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop_act,
  input  logic en,
  input  logic fr,
  output logic t_out,
  output logic c_out,
  output logic c_oe
);
  pair_st_e st_q, st_d;
  logic     ph_q, ph_d;
  logic     park_req;

  always_comb begin
    park_req = ~en | (stop_act & ~fr);
    st_d     = st_q;
    ph_d     = ph_q;
    if (tick) begin
      if (park_req && ph_q) begin
        st_d = PS_PARK;
        ph_d = 1'b1;
      end else begin
        st_d = PS_RUN;
        ph_d = ~ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_RUN;
      ph_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  always_comb begin
    t_out = ph_q;
    c_oe  = (st_q == PS_RUN);
    c_out = c_oe ? ~ph_q : 1'b0;
  end
endmodule

// File: rtl/cpu_clk_stop_ctrl.sv
module cpu_clk_stop_ctrl #(
  parameter int NUM_PAIRS = 3,
  parameter int HALF_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_n,
  input  logic                 cfg_wr,
  input  logic [NUM_PAIRS-1:0] cfg_en,
  input  logic [NUM_PAIRS-1:0] cfg_fr,
  output logic [NUM_PAIRS-1:0] clk_t,
  output logic [NUM_PAIRS-1:0] clk_c,
  output logic [NUM_PAIRS-1:0] clk_c_oe,
  output logic                 stop_seen_n
);
  logic rst_m_q, rst_q_n;
  logic tick;
  logic stop_act;
  logic [NUM_PAIRS-1:0] en_q, fr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  cstop_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tick  (tick)
  );

  cstop_req_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .tick        (tick),
    .stop_n      (stop_n),
    .stop_seen_n (stop_seen_n)
  );

  assign stop_act = ~stop_seen_n;

  cstop_cfg #(.NP(NUM_PAIRS)) u_cfg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr    (cfg_wr),
    .en_in (cfg_en),
    .fr_in (cfg_fr),
    .en_q  (en_q),
    .fr_q  (fr_q)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    cstop_pair u_pair (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .tick     (tick),
      .stop_act (stop_act),
      .en       (en_q[g]),
      .fr       (fr_q[g]),
      .t_out    (clk_t[g]),
      .c_out    (clk_c[g]),
      .c_oe     (clk_c_oe[g])
    );
  end
endmodule

// File: rtl/cpu_clk_stop_ctrl_chk.sv
module cpu_clk_stop_ctrl_chk #(
  parameter int NP = 3
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          tick,
  input logic [NP-1:0] en_q,
  input logic [NP-1:0] fr_q,
  input logic          stop_seen_n,
  input logic [NP-1:0] clk_t,
  input logic [NP-1:0] clk_c,
  input logic [NP-1:0] clk_c_oe
);
  p_status_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stop_seen_n != $past(stop_seen_n)) |-> $past(tick));

  for (genvar i = 0; i < NP; i++) begin : g_chk
    p_park_level_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
      !clk_c_oe[i] |-> (clk_t[i] && !clk_c[i]));

    p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (clk_t[i] != $past(clk_t[i])) |-> $past(tick));

    p_free_run_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tick && en_q[i] && fr_q[i]) |=> (clk_t[i] != $past(clk_t[i])));

    p_disable_park_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tick && !en_q[i] && clk_t[i]) |=> !clk_c_oe[i]);

    p_release_fall_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(clk_c_oe[i]) |-> $fell(clk_t[i]));
  end
endmodule

bind cpu_clk_stop_ctrl cpu_clk_stop_ctrl_chk #(.NP(NUM_PAIRS)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .tick        (tick),
  .en_q        (en_q),
  .fr_q        (fr_q),
  .stop_seen_n (stop_seen_n),
  .clk_t       (clk_t),
  .clk_c       (clk_c),
  .clk_c_oe    (clk_c_oe)
);

// File: tb/test_cpu_clk_stop_ctrl.sv
module test_cpu_clk_stop_ctrl;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stop_n;
  logic          cfg_wr;
  logic [NP-1:0] cfg_en, cfg_fr;
  logic [NP-1:0] clk_t, clk_c, clk_c_oe;
  logic          stop_seen_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cnt [NP];
  logic [NP-1:0] prev_t;

  cpu_clk_stop_ctrl #(.NUM_PAIRS(NP), .HALF_DIV(2)) i_cpu_clk_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_fr(cfg_fr), .clk_t(clk_t), .clk_c(clk_c),
    .clk_c_oe(clk_c_oe), .stop_seen_n(stop_seen_n)
  );

  always #5 clk = ~clk;

  initial begin
    for (int i = 0; i < NP; i++) cnt[i] = 0;
    prev_t = '0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < NP; i++)
      if (clk_t[i] !== prev_t[i]) cnt[i] = cnt[i] + 1;
    prev_t = clk_t;
  end

  function automatic int park_count(logic level_at_fall);
    return level_at_fall ? 2 : 3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [NP-1:0] en, input logic [NP-1:0] fr);
    cfg_en = en; cfg_fr = fr; cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
    step(1);
  endtask

  task automatic measure(input int n, output int d [NP]);
    int base [NP];
    for (int i = 0; i < NP; i++) base[i] = cnt[i];
    step(n);
    for (int i = 0; i < NP; i++) d[i] = cnt[i] - base[i];
  endtask

  task automatic check_running(input string req);
    for (int i = 0; i < NP; i++) begin
      check(clk_c_oe[i] == 1'b1, req, "complement drive enabled", clk_c_oe[i], 1);
      check(clk_c[i] == ~clk_t[i], req, "complement inverse of true", clk_c[i], ~clk_t[i]);
    end
  endtask

  task automatic stop_cycle(input logic [NP-1:0] fr, input int offs);
    int d [NP];
    int base [NP];
    logic [NP-1:0] p0;
    write_cfg('1, fr);
    step(offs);
    p0 = clk_t;
    for (int i = 0; i < NP; i++) base[i] = cnt[i];
    stop_n = 1'b0;
    step(24);
    for (int i = 0; i < NP; i++) begin
      d[i] = cnt[i] - base[i];
      if (fr[i]) begin
        check(d[i] == 12, "R5", "free-run transitions during stop", d[i], 12);
      end else begin
        check(d[i] == park_count(p0[i]), "R3", "transitions until park", d[i], park_count(p0[i]));
        check(clk_t[i] && !clk_c[i] && !clk_c_oe[i], "R4", "parked levels t/c/oe",
              {clk_t[i], clk_c[i], clk_c_oe[i]}, 3'b100);
      end
    end
    check(stop_seen_n == 1'b0, "R8", "status low while stopped", stop_seen_n, 0);
    stop_n = 1'b1;
    measure(16, d);
    for (int i = 0; i < NP; i++) begin
      if (fr[i]) check(d[i] == 8, "R5", "free-run transitions after release", d[i], 8);
      else       check(d[i] == 6, "R7", "transitions after release", d[i], 6);
    end
    check_running("R7");
    check(stop_seen_n == 1'b1, "R8", "status high after release", stop_seen_n, 1);
  endtask

  initial begin
    int d [NP];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stop_n = 1'b1; cfg_wr = 1'b0; cfg_en = '1; cfg_fr = '0;
    step(4);
    rst_n = 1'b1;
    step(6);

    // R1, R2: reset state and free toggling
    measure(16, d);
    for (int i = 0; i < NP; i++)
      check(d[i] == 8, "R2", "running transitions in 16 cycles", d[i], 8);
    check_running("R1");
    check(stop_seen_n == 1'b1, "R8", "status after reset", stop_seen_n, 1);

    // R3/R4/R5/R7/R9: every free-run mask, random phase offsets
    for (int m = 0; m < (1 << NP); m++) begin
      stop_cycle(NP'(m), int'($urandom_range(0, 3)));
      stop_cycle(NP'(m), int'($urandom_range(0, 3)));
    end

    // R6: disabled pair parks even when marked free-running
    write_cfg(3'b101, 3'b111);
    step(8);
    measure(16, d);
    check(d[1] == 0, "R6", "disabled pair transitions", d[1], 0);
    check(clk_t[1] && !clk_c[1] && !clk_c_oe[1], "R6", "disabled pair parked",
          {clk_t[1], clk_c[1], clk_c_oe[1]}, 3'b100);
    check(d[0] == 8 && d[2] == 8, "R9", "other pairs unaffected", d[0] + d[2], 16);
    write_cfg(3'b111, 3'b111);
    step(4);
    measure(16, d);
    check(d[1] == 8, "R6", "re-enabled pair transitions", d[1], 8);
    check_running("R6");

    // R1: reset over non-default configuration restores defaults
    write_cfg(3'b000, 3'b111);
    step(8);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(6);
    measure(16, d);
    for (int i = 0; i < NP; i++)
      check(d[i] == 8, "R1", "toggling after reset", d[i], 8);
    stop_n = 1'b0;
    step(24);
    for (int i = 0; i < NP; i++)
      check(!clk_c_oe[i] && clk_t[i], "R1", "default stoppable after reset",
            {clk_t[i], clk_c_oe[i]}, 2'b10);
    stop_n = 1'b1;
    step(16);
    check_running("R1");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule